// File: doc/BRIEF.md
# Packed Interval Half-Precision Multiplier

This block multiplies two closed intervals whose end points are half-precision floating-point numbers. Each operand interval travels in one 32-bit word, lower end point in the low half and upper end point in the high half. The result is packed the same way. The new lower end point is the smallest of the four end-point products, rounded toward minus infinity. The new upper end point is the largest of the four, rounded toward plus infinity. Both directed roundings come out of one instruction, so software never has to change a rounding mode between the two halves.

A host processor uses the block as a multi-cycle extension instruction. It presents both words with `start` in an enabled cycle and waits for `done`. A single significand multiplier serves the four end-point pairs in turn. For each pair it produces a round-down and a round-up result, and two trackers keep the running minimum and maximum. Every register advances only in cycles where `clk_en` is high.

The controller has three states. IDLE waits for a request; the transition IDLE→PROD is taken on `start` and captures both operands. PROD visits pair index 0 to 3; the transition PROD→DONE is taken after index 3. DONE shows `done`; the transition DONE→IDLE follows one enabled cycle. All transitions happen only on enabled edges.

Top module: `ipm_top`

## Requirements
- R1: An end point has sign in bit 15, a 5-bit exponent with bias 15 in bits 14:10, and fraction in bits 9:0. The lower end point sits in bits 15:0 and the upper end point in bits 31:16, for operands and result alike. An operand end point with exponent field 0 is read as zero. Operand exponent fields are never 31.
- R2: The lower result is the greatest value, among zero, the normal numbers and ±infinity, that does not exceed the minimum exact product of an `dataa` end point and a `datab` end point.
- R3: The upper result is the least value from the same set that is not below the maximum exact product.
- R4: A product whose magnitude exceeds 65504 gives infinity (0x7C00 or 0xFC00) when rounding away from zero. It gives ±65504 (0x7BFF or 0xFBFF) when rounding toward zero.
- R5: A non-zero product with magnitude below 2^-14 gives 0x0000 when rounding toward zero. It gives ±2^-14 (0x0400 or 0x8400) when rounding away from zero.
- R6: A zero result is always encoded 0x0000. No result end point has exponent field 0 with a non-zero remainder.
- R7: `done` is high during exactly one enabled cycle per accepted request. `done` rises after the fifth enabled clock edge, counting the edge that accepts `start`.
- R8: While `clk_en` is low, `done`, `result` and the controller state hold their values.
- R9: `start` is ignored outside IDLE. A request is accepted only in IDLE, and the operands captured then are the ones multiplied.
- R10: While `reset` is high, and right after it is released, `done` is 0 and `result` is 0. `reset` also aborts an operation in progress.
- R11: For every accepted request, the lower result never exceeds the upper result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clk_en | input | 1 | Advances all registers when high |
| reset | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests an operation in IDLE |
| dataa | input | 32 | First operand interval {upper, lower} |
| datab | input | 32 | Second operand interval {upper, lower} |
| result | output | 32 | Product interval {upper, lower} |
| done | output | 1 | Result valid for one enabled cycle |

## Verification
The assertions assume that operand exponent fields never hold 31, because infinities and NaNs are not valid operands. The assertions do not assume the lower end point is at most the upper end point, since the products cover all four pairings anyway. The stimulus builds its end points from exponents 0 to 30 only, and a check at capture time flags any request that breaks this. The sweep orders each operand pair by value so that the intervals are well formed. Directed cases push products past 65504 and below 2^-14 in both signs.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 10;
    localparam int BIAS    = 15;
    localparam int HW      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int WORD_W  = 2 * HW;
    localparam int PAIRS   = 4;
    localparam int IDX_W   = $clog2(PAIRS);

    typedef logic [HW-1:0] half_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROD,
        ST_DONE
    } ipm_state_t;

    // Signed ordering key: both zero encodings map to 0, infinities sort outermost.
    function automatic logic signed [HW+1:0] half_key(input half_t h);
        logic signed [HW+1:0] mag;
        mag = $signed({3'b000, h[HW-2:0]});
        if (h[HW-2 -: EXP_W] == '0) mag = '0;
        return h[HW-1] ? -mag : mag;
    endfunction
endpackage

// File: rtl/ipm_bound_mul.sv
module ipm_bound_mul
    import ipm_pkg::*;
(
    input  half_t op_x,
    input  half_t op_y,
    output half_t prod_dn,
    output half_t prod_up
);
    localparam int EW = EXP_W + 3;
    localparam logic signed [EW-1:0] EXP_TOP = EW'(EXP_MAX);
    localparam logic signed [EW-1:0] EXP_ONE = EW'(1);

    logic                     res_sign;
    logic                     res_zero;
    logic                     inexact;
    logic [PROD_W-1:0]        prod;
    logic [SIG_W-1:0]         mant_t;
    logic signed [EW-1:0]     ex_s;
    logic signed [EW-1:0]     ey_s;
    logic signed [EW-1:0]     exp_t;

    always_comb begin
        res_sign = op_x[HW-1] ^ op_y[HW-1];
        res_zero = (op_x[HW-2 -: EXP_W] == '0) || (op_y[HW-2 -: EXP_W] == '0);
        prod = PROD_W'({1'b1, op_x[FRAC_W-1:0]}) * PROD_W'({1'b1, op_y[FRAC_W-1:0]});
        ex_s = {3'b000, op_x[HW-2 -: EXP_W]};
        ey_s = {3'b000, op_y[HW-2 -: EXP_W]};
        if (prod[PROD_W-1]) begin
            mant_t  = prod[PROD_W-1 -: SIG_W];
            inexact = |prod[SIG_W-1:0];
        end else begin
            mant_t  = prod[PROD_W-2 -: SIG_W];
            inexact = |prod[SIG_W-2:0];
        end
        exp_t = ex_s + ey_s - EW'(BIAS) + {{(EW-1){1'b0}}, prod[PROD_W-1]};
    end

    // Direction 0 rounds toward minus infinity, direction 1 toward plus infinity.
    for (genvar gd = 0; gd < 2; gd++) begin : g_dir
        logic                 grow;
        logic [SIG_W:0]       mant_r;
        logic signed [EW-1:0] exp_r;
        half_t                res;

        always_comb begin
            grow   = (gd == 0) ? res_sign : ~res_sign;
            mant_r = {1'b0, mant_t} + {{SIG_W{1'b0}}, (inexact & grow)};
            exp_r  = exp_t;
            if (mant_r[SIG_W]) begin
                mant_r = mant_r >> 1;
                exp_r  = exp_t + EXP_ONE;
            end
            if (res_zero)
                res = '0;
            else if (exp_r >= EXP_TOP)
                res = grow ? {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                           : {res_sign, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
            else if (exp_r < EXP_ONE)
                res = grow ? {res_sign, EXP_W'(1), {FRAC_W{1'b0}}} : '0;
            else
                res = {res_sign, exp_r[EXP_W-1:0], mant_r[FRAC_W-1:0]};
        end

        always_comb begin
            if (!res_zero)
                assert_hidden_R2: assert (mant_r[SIG_W] == 1'b0 && mant_r[FRAC_W] == 1'b1)
                    else $error("significand not normalised");
            assert_zero_enc_R6: assert (res[HW-2 -: EXP_W] != '0 || res == '0)
                else $error("bad zero or denormal encoding");
        end

        if (gd == 0) begin : g_dn
            assign prod_dn = res;
        end else begin : g_up
            assign prod_up = res;
        end
    end

    always_comb begin
        assert_no_overflow_R4: assert (prod_dn != {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                                    && prod_up != {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}})
            else $error("infinity produced against rounding direction");
    end
endmodule

// File: rtl/ipm_bound_track.sv
module ipm_bound_track
    import ipm_pkg::*;
#(
    parameter bit KEEP_MAX = 1'b0
) (
    input  logic  clk,
    input  logic  reset,
    input  logic  step,
    input  logic  first,
    input  half_t cand,
    output half_t bound
);
    logic better;

    always_comb begin
        if (KEEP_MAX)
            better = half_key(cand) > half_key(bound);
        else
            better = half_key(cand) < half_key(bound);
    end

    always_ff @(posedge clk) begin
        if (reset)
            bound <= '0;
        else if (step && (first || better))
            bound <= cand;
    end
endmodule

// File: rtl/ipm_top.sv
module ipm_top
    import ipm_pkg::*;
(
    input  logic              clk,
    input  logic              clk_en,
    input  logic              reset,
    input  logic              start,
    input  logic [WORD_W-1:0] dataa,
    input  logic [WORD_W-1:0] datab,
    output logic [WORD_W-1:0] result,
    output logic              done
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAIRS - 1);

    ipm_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] opa_q, opb_q;
    half_t             sel_x, sel_y;
    half_t             cand [2];
    half_t             bnd  [2];
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (reset)
            state_q <= ST_IDLE;
        else if (clk_en)
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PROD;
            ST_PROD: if (idx_q == IDX_LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Operand capture and pair index
    always_ff @(posedge clk) begin
        if (reset) begin
            idx_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else if (clk_en) begin
            if (accept) begin
                opa_q <= dataa;
                opb_q <= datab;
                idx_q <= '0;
            end else if (state_q == ST_PROD) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // idx bit 1 picks the dataa end point, bit 0 the datab end point
    assign sel_x = idx_q[1] ? opa_q[WORD_W-1 -: HW] : opa_q[HW-1:0];
    assign sel_y = idx_q[0] ? opb_q[WORD_W-1 -: HW] : opb_q[HW-1:0];

    ipm_bound_mul u_mul (
        .op_x    (sel_x),
        .op_y    (sel_y),
        .prod_dn (cand[0]),
        .prod_up (cand[1])
    );

    for (genvar gi = 0; gi < 2; gi++) begin : g_trk
        ipm_bound_track #(.KEEP_MAX(gi == 1)) u_trk (
            .clk   (clk),
            .reset (reset),
            .step  (clk_en && state_q == ST_PROD),
            .first (idx_q == '0),
            .cand  (cand[gi]),
            .bound (bnd[gi])
        );
    end

    // Outputs
    always_comb begin
        done   = (state_q == ST_DONE);
        result = {bnd[1], bnd[0]};
    end

    assert_input_finite_R1: assert property (@(posedge clk) disable iff (reset)
        (accept && clk_en) |-> (dataa[HW-2 -: EXP_W] != '1 && dataa[WORD_W-2 -: EXP_W] != '1
                              && datab[HW-2 -: EXP_W] != '1 && datab[WORD_W-2 -: EXP_W] != '1))
        else $error("non-finite operand");

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (reset)
        (done && clk_en) |=> !done)
        else $error("done longer than one enabled cycle");

    assert_stall_R8: assert property (@(posedge clk) disable iff (reset)
        !clk_en |=> ($stable(result) && $stable(done) && $stable(state_q)))
        else $error("progress while clk_en low");

    assert_busy_R9: assert property (@(posedge clk) disable iff (reset)
        (state_q != ST_IDLE) |=> ($stable(opa_q) && $stable(opb_q)))
        else $error("operands changed while busy");

    assert_order_R11: assert property (@(posedge clk) disable iff (reset)
        done |-> (half_key(result[HW-1:0]) <= half_key(result[WORD_W-1 -: HW])))
        else $error("lower end above upper end");
endmodule

// File: tb/ipm_top_test.sv
`timescale 1ns/1ps
module ipm_top_test;
    logic        clk = 1'b0;
    logic        clk_en = 1'b1;
    logic        reset = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dataa = '0;
    logic [31:0] datab = '0;
    logic [31:0] result;
    logic        done;

    int total = 0;
    int bad = 0;
    logic [15:0] plo [300];
    logic [15:0] phi [300];

    always #2.5 clk = ~clk;

    ipm_top uut (
        .clk(clk), .clk_en(clk_en), .reset(reset), .start(start),
        .dataa(dataa), .datab(datab), .result(result), .done(done)
    );

    task automatic check(input bit ok, input string req, input string detail);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", req, detail);
        end
    endtask

    function automatic real h2r(input logic [15:0] h);
        int  e;
        real m;
        e = int'(h[14:10]);
        if (e == 0) return 0.0;
        if (e == 31) return h[15] ? -1.0e30 : 1.0e30;
        m = real'(1024 + int'(h[9:0])) * (2.0 ** (e - 25));
        return h[15] ? -m : m;
    endfunction

    function automatic real succ_r(input logic [15:0] h);
        if (h[14:10] == 5'd0) return 2.0 ** (-14);
        if (!h[15]) return (h == 16'h7C00) ? 1.0e31 : h2r(h + 16'd1);
        return (h[14:0] == 15'h0400) ? 0.0 : h2r(h - 16'd1);
    endfunction

    function automatic real pred_r(input logic [15:0] h);
        if (h[14:10] == 5'd0) return -(2.0 ** (-14));
        if (h[15]) return (h == 16'hFC00) ? -1.0e31 : h2r(h + 16'd1);
        return (h == 16'h0400) ? 0.0 : h2r(h - 16'd1);
    endfunction

    function automatic bit enc_ok(input logic [15:0] h);
        return !(h[14:10] == 5'd0 && h != 16'h0000);
    endfunction

    function automatic logic [15:0] sample(input int k);
        int ex;
        int fr;
        case (k / 2)
            0: ex = 0;   1: ex = 1;   2: ex = 2;   3: ex = 7;
            4: ex = 13;  5: ex = 14;  6: ex = 15;  7: ex = 16;
            8: ex = 17;  9: ex = 23;  10: ex = 29; default: ex = 30;
        endcase
        fr = (k * 173 + k * k * 11) % 1024;
        if (ex == 0) return 16'h0000;
        return {k[0], 5'(ex), 10'(fr)};
    endfunction

    // Drive one request at a falling edge, count falling edges until done.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, output int lat);
        start = 1'b1; dataa = a; datab = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic op_check(input logic [31:0] a, input logic [31:0] b);
        real pr [4];
        real mn, mx;
        int  lat;
        logic [15:0] lo, hi;
        pr[0] = h2r(a[15:0])  * h2r(b[15:0]);
        pr[1] = h2r(a[15:0])  * h2r(b[31:16]);
        pr[2] = h2r(a[31:16]) * h2r(b[15:0]);
        pr[3] = h2r(a[31:16]) * h2r(b[31:16]);
        mn = pr[0]; mx = pr[0];
        for (int i = 1; i < 4; i++) begin
            if (pr[i] < mn) mn = pr[i];
            if (pr[i] > mx) mx = pr[i];
        end
        run_op(a, b, lat);
        lo = result[15:0];
        hi = result[31:16];
        check(lat == 5, "R7", $sformatf("latency act=%0d exp=5", lat));
        check(h2r(lo) <= mn && succ_r(lo) > mn, "R2",
              $sformatf("a=%h b=%h lower act=%h (%g) exp floor of %g", a, b, lo, h2r(lo), mn));
        check(h2r(hi) >= mx && pred_r(hi) < mx, "R3",
              $sformatf("a=%h b=%h upper act=%h (%g) exp ceil of %g", a, b, hi, h2r(hi), mx));
        check(enc_ok(lo) && enc_ok(hi), "R6", $sformatf("encoding act=%h exp no denormal/-0", result));
        @(negedge clk);
        check(!done, "R7", $sformatf("done after pulse act=%b exp=0", done));
    endtask

    task automatic exact_case(input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] want, input string req);
        int lat;
        run_op(a, b, lat);
        check(result == want, req, $sformatf("a=%h b=%h act=%h exp=%h", a, b, result, want));
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int n;
        logic [31:0] held;
        n = 0;
        for (int i = 0; i < 24; i++)
            for (int j = i; j < 24; j++) begin
                if (h2r(sample(i)) <= h2r(sample(j))) begin
                    plo[n] = sample(i); phi[n] = sample(j);
                end else begin
                    plo[n] = sample(j); phi[n] = sample(i);
                end
                n++;
            end

        // R10: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0 && result == 32'h0, "R10", $sformatf("in reset act=%b/%h exp=0/0", done, result));
        reset = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && result == 32'h0, "R10", $sformatf("after reset act=%b/%h exp=0/0", done, result));

        // R4, R5, R1, R2, R3 directed values
        exact_case(32'h7BFF_7BFF, 32'h7BFF_7BFF, 32'h7C00_7BFF, "R4");
        exact_case(32'hFBFF_FBFF, 32'h7BFF_7BFF, 32'hFBFF_FC00, "R4");
        exact_case(32'h0400_0400, 32'h0400_0400, 32'h0400_0000, "R5");
        exact_case(32'h8400_8400, 32'h0400_0400, 32'h0000_8400, "R5");
        exact_case(32'h3C00_0000, 32'h4000_C000, 32'h4000_C000, "R1");
        exact_case(32'h0001_0001, 32'h3C00_3C00, 32'h0000_0000, "R1");
        exact_case(32'h3C00_3C00, 32'h3C00_3C00, 32'h3C00_3C00, "R2");
        exact_case(32'h3C01_3C01, 32'h3C01_3C01, 32'h3C03_3C02, "R3");
        exact_case(32'hBC01_BC01, 32'h3C01_3C01, 32'hBC02_BC03, "R2");
        exact_case(32'h4000_BC00, 32'h4000_BC00, 32'h4400_C000, "R11");

        // R9: start held with other operands while busy
        start = 1'b1; dataa = 32'h3C01_3C01; datab = 32'h3C01_3C01;
        @(negedge clk);
        dataa = 32'h4000_4000; datab = 32'h4000_4000;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 3;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check(result == 32'h3C03_3C02 && lat == 5, "R9",
              $sformatf("act=%h lat=%0d exp=3c033c02 lat=5", result, lat));
        @(negedge clk);

        // R8: stall mid-operation, then hold done under stall
        start = 1'b1; dataa = 32'hBC01_BC01; datab = 32'h3C01_3C01;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        clk_en = 1'b0;
        @(negedge clk);
        held = result;
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            check(!done && result == held, "R8", $sformatf("stall act=%b/%h exp=0/%h", done, result, held));
        end
        clk_en = 1'b1;
        lat = 2;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check(result == 32'hBC02_BC03 && lat == 5, "R8",
              $sformatf("after stall act=%h lat=%0d exp=bc02bc03 lat=5", result, lat));
        clk_en = 1'b0;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check(done, "R7", $sformatf("done under stall act=%b exp=1", done));
        end
        clk_en = 1'b1;
        @(negedge clk);
        check(!done, "R7", $sformatf("done after enabled cycle act=%b exp=0", done));

        // R10: reset aborts an operation
        start = 1'b1; dataa = 32'h4000_4000; datab = 32'h4000_4000;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reset = 1'b1;
        @(negedge clk);
        reset = 1'b0;
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            check(!done && result == 32'h0, "R10", $sformatf("abort act=%b/%h exp=0/0", done, result));
        end

        // Near-exhaustive sweep over ordered end-point pairs
        for (int ia = 0; ia < 300; ia++)
            for (int ib = ia % 7; ib < 300; ib += 7)
                op_check({phi[ia], plo[ia]}, {phi[ib], plo[ib]});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule